// File: doc/BRIEF.md
# DMA Channel Service Scheduler

This block decides which DMA channel is served next and tracks how far each transfer has progressed. The system has two controllers of four channels each. Channels 0 to 3 belong to a byte-wide controller and channels 4 to 7 to a word-wide controller. A one-cycle `tick` starts a scan. The scan walks the channel numbers in ascending order and serves each channel that is requesting, is not masked, and sits on a controller that is not switched off. For each such channel the block opens a request/acknowledge exchange with the device side. It offers the position reached so far and the total transfer length, both scaled to bytes for the word-wide controller. It then takes back the new position.

On acknowledgement the block scales the returned position back into channel units and emits a one-cycle write of the new current count. If the transfer has just completed, it also emits a one-cycle terminal-count pulse for that channel. An outer register file holds the command, mask, mode and count state and applies these updates. The block never touches memory itself. It only marks, through a write-enable qualifier, whether the device side may write memory for the transfer being offered.

Top module: `dma_svc_engine`

## Requirements
- R1: After reset `xferReq`, `cntWe` and every `tcPulse` bit are low, and they stay low until a `tick` arrives.
- R2: A `tick` starts one scan over channels 0 to 7 in ascending order, and every eligible channel is served exactly once in that order.
- R3: Every channel of a controller whose command byte has bit 2 (value 0x04) set is skipped during the scan.
- R4: A channel is served only when its `chanMask` bit is 0 and its `chanReq` bit is 1, sampled when the scan reaches it. A mask set after the scan starts, but before the scan reaches the channel, prevents service in that scan and in the next one.
- R5: The width shift is 0 for channels 0 to 3 and 1 for channels 4 to 7. `xferStart` equals the current count shifted left by the width shift. `xferSize` equals (base count + 1) shifted left by the width shift.
- R6: In the cycle after `xferAck` is sampled high with `xferReq`, `cntWe` pulses for one cycle. At that point `cntChan` names the served channel and `cntData` equals `xferEnd` shifted right by the width shift, truncated to the count width.
- R7: A terminal-count pulse on `tcPulse[ch]` accompanies the count write when the shifted end count equals base count + 1 and mode bits [7:6] are 0 (demand), 1 (single) or 2 (block).
- R8: No terminal-count pulse is ever produced for a channel in cascade mode (mode bits [7:6] = 3), even when its end count reaches base count + 1.
- R9: `xferMemWrite` is high only while a request is offered for a channel whose mode bits [3:2] are 1 (write). It stays low for verify (0), read (2) and illegal (3).
- R10: An end count below the start count is accepted as an auto-init wraparound. It is stored in the normal way and raises terminal count only under R7.
- R11: While `xferReq` is high and `xferAck` is low, the request stays high and `xferChan` stays unchanged. The scan moves to the next channel only after the acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Starts one service scan; ignored while a scan is running |
| ctrlCmd | input | NUM_CTRL x 8 | Command byte per controller; bit 2 switches the controller off |
| chanMask | input | NCH | Per-channel mask, 1 = masked |
| chanReq | input | NCH | Per-channel request level |
| chanMode | input | NCH x 8 | Mode byte per channel; [7:6] operating mode, [3:2] transfer type |
| baseCount | input | NCH x CNT_W | Programmed base count per channel |
| curCount | input | NCH x CNT_W | Current count per channel |
| xferReq | output | 1 | Service request to the device side |
| xferChan | output | PTR_W | Channel being served |
| xferStart | output | XW | Start position in bytes |
| xferSize | output | XW | Total length in bytes |
| xferMemWrite | output | 1 | Device side may write memory for this transfer |
| xferAck | input | 1 | Device side has finished the service slot |
| xferEnd | input | XW | End position returned by the device side, in bytes |
| cntWe | output | 1 | One-cycle current-count write strobe |
| cntChan | output | PTR_W | Channel whose current count is written |
| cntData | output | CNT_W | New current count |
| tcPulse | output | NCH | One-cycle terminal-count set pulse per channel |

## Verification
The scans are run with every channel requesting at once, under a mix of modes and transfer types. This separates the terminal-count rule for demand, single and block mode from the cascade exception, the write qualifier from verify, read and illegal types, and the byte-wide scaling from the word-wide scaling. Further scans switch off each controller in turn, apply a sparse mask, and mask a channel just after the tick. These show that eligibility is sampled per channel as the scan reaches it, and that each controller's off bit acts only on its own four channels. A returned position below the start position checks that wraparound is stored without raising terminal count. A scan with no requests checks that the block stays silent. Every acknowledgement is delayed by one cycle, so a request that does not hold steady shows up as a failed check.

// File: rtl/dma_svc_pkg.sv
package dma_svc_pkg;

  typedef enum logic [1:0] {
    SVC_IDLE = 2'd0,
    SVC_SCAN = 2'd1,
    SVC_WAIT = 2'd2
  } svcState_e;

  // Strobes from the scan control to the count datapath
  typedef struct packed {
    logic offer;   // a request is presented this cycle
    logic commit;  // the device acknowledged the current offer
  } svcStrobe_t;

endpackage

// File: rtl/dma_svc_ctrl.sv
module dma_svc_ctrl
  import dma_svc_pkg::*;
#(
  parameter int NUM_CTRL    = 2,
  parameter int CH_PER_CTRL = 4,
  parameter int NCH         = NUM_CTRL * CH_PER_CTRL,
  parameter int PTR_W       = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic [NUM_CTRL-1:0] ctrlOff,
  input  logic [NCH-1:0]      chanMask,
  input  logic [NCH-1:0]      chanReq,
  input  logic                xferAck,
  output svcStrobe_t          strobe,
  output logic [PTR_W-1:0]    ptr
);

  svcState_e state;
  logic      ctrlIsOff;
  logic      eligible;
  logic      lastPtr;

  // Pick the off bit of the controller owning the current pointer
  always_comb begin
    ctrlIsOff = 1'b0;
    for (int k = 0; k < NUM_CTRL; k++) begin
      if (int'(ptr) / CH_PER_CTRL == k) ctrlIsOff = ctrlOff[k];
    end
  end

  assign eligible = !ctrlIsOff && !chanMask[ptr] && chanReq[ptr];
  assign lastPtr  = (ptr == PTR_W'(NCH - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SVC_IDLE;
      ptr   <= '0;
    end else begin
      case (state)
        SVC_IDLE: begin
          if (tick) begin
            state <= SVC_SCAN;
            ptr   <= '0;
          end
        end
        SVC_SCAN: begin
          if (eligible) begin
            state <= SVC_WAIT;
          end else if (lastPtr) begin
            state <= SVC_IDLE;
          end else begin
            ptr <= ptr + PTR_W'(1);
          end
        end
        SVC_WAIT: begin
          if (xferAck) begin
            if (lastPtr) begin
              state <= SVC_IDLE;
            end else begin
              state <= SVC_SCAN;
              ptr   <= ptr + PTR_W'(1);
            end
          end
        end
        default: state <= SVC_IDLE;
      endcase
    end
  end

  assign strobe.offer  = (state == SVC_WAIT);
  assign strobe.commit = (state == SVC_WAIT) && xferAck;

endmodule

// File: rtl/dma_svc_dp.sv
module dma_svc_dp
  import dma_svc_pkg::*;
#(
  parameter int                NUM_CTRL    = 2,
  parameter int                CH_PER_CTRL = 4,
  parameter int                CNT_W       = 16,
  parameter logic [NUM_CTRL-1:0] CTRL_WIDE = 2'b10,
  parameter int                NCH         = NUM_CTRL * CH_PER_CTRL,
  parameter int                PTR_W       = $clog2(NCH),
  parameter int                XW          = CNT_W + 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  svcStrobe_t                strobe,
  input  logic [PTR_W-1:0]          ptr,
  input  logic [NCH-1:0][7:0]       chanMode,
  input  logic [NCH-1:0][CNT_W-1:0] baseCount,
  input  logic [NCH-1:0][CNT_W-1:0] curCount,
  input  logic [XW-1:0]             xferEnd,
  output logic [XW-1:0]             xferStart,
  output logic [XW-1:0]             xferSize,
  output logic                      xferMemWrite,
  output logic                      cntWe,
  output logic [PTR_W-1:0]          cntChan,
  output logic [CNT_W-1:0]          cntData,
  output logic [NCH-1:0]            tcPulse
);

  logic             wide;
  logic [7:0]       selMode;
  logic [XW-1:0]    selBase1;
  logic [XW-1:0]    endScaled;
  logic             endHit;
  logic             isCascade;

  // Width shift of the controller owning the pointer
  always_comb begin
    wide = 1'b0;
    for (int k = 0; k < NUM_CTRL; k++) begin
      if (int'(ptr) / CH_PER_CTRL == k) wide = CTRL_WIDE[k];
    end
  end

  assign selMode   = chanMode[ptr];
  assign selBase1  = XW'(baseCount[ptr]) + XW'(1);
  assign xferStart = XW'(curCount[ptr]) << wide;
  assign xferSize  = selBase1 << wide;
  assign endScaled = xferEnd >> wide;
  assign endHit    = (endScaled == selBase1);
  assign isCascade = (selMode[7:6] == 2'b11);

  // Only a write-type transfer may touch memory
  assign xferMemWrite = strobe.offer && (selMode[3:2] == 2'b01);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntWe   <= 1'b0;
      cntChan <= '0;
      cntData <= '0;
      tcPulse <= '0;
    end else begin
      cntWe   <= strobe.commit;
      tcPulse <= '0;
      if (strobe.commit) begin
        cntChan <= ptr;
        cntData <= endScaled[CNT_W-1:0];
        if (endHit && !isCascade) tcPulse[ptr] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_svc_engine.sv
module dma_svc_engine
  import dma_svc_pkg::*;
#(
  parameter int                  NUM_CTRL    = 2,
  parameter int                  CH_PER_CTRL = 4,
  parameter int                  CNT_W       = 16,
  parameter logic [NUM_CTRL-1:0] CTRL_WIDE   = 2'b10,
  localparam int                 NCH         = NUM_CTRL * CH_PER_CTRL,
  localparam int                 PTR_W       = $clog2(NCH),
  localparam int                 XW          = CNT_W + 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tick,
  input  logic [NUM_CTRL-1:0][7:0]     ctrlCmd,
  input  logic [NCH-1:0]               chanMask,
  input  logic [NCH-1:0]               chanReq,
  input  logic [NCH-1:0][7:0]          chanMode,
  input  logic [NCH-1:0][CNT_W-1:0]    baseCount,
  input  logic [NCH-1:0][CNT_W-1:0]    curCount,
  output logic                         xferReq,
  output logic [PTR_W-1:0]             xferChan,
  output logic [XW-1:0]                xferStart,
  output logic [XW-1:0]                xferSize,
  output logic                         xferMemWrite,
  input  logic                         xferAck,
  input  logic [XW-1:0]                xferEnd,
  output logic                         cntWe,
  output logic [PTR_W-1:0]             cntChan,
  output logic [CNT_W-1:0]             cntData,
  output logic [NCH-1:0]               tcPulse
);

  svcStrobe_t          strobe;
  logic [PTR_W-1:0]    ptr;
  logic [NUM_CTRL-1:0] ctrlOff;

  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_off
    assign ctrlOff[k] = ctrlCmd[k][2];
  end

  dma_svc_ctrl #(
    .NUM_CTRL(NUM_CTRL), .CH_PER_CTRL(CH_PER_CTRL), .NCH(NCH), .PTR_W(PTR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .ctrlOff(ctrlOff),
    .chanMask(chanMask), .chanReq(chanReq), .xferAck(xferAck),
    .strobe(strobe), .ptr(ptr)
  );

  dma_svc_dp #(
    .NUM_CTRL(NUM_CTRL), .CH_PER_CTRL(CH_PER_CTRL), .CNT_W(CNT_W),
    .CTRL_WIDE(CTRL_WIDE), .NCH(NCH), .PTR_W(PTR_W), .XW(XW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ptr(ptr),
    .chanMode(chanMode), .baseCount(baseCount), .curCount(curCount),
    .xferEnd(xferEnd), .xferStart(xferStart), .xferSize(xferSize),
    .xferMemWrite(xferMemWrite), .cntWe(cntWe), .cntChan(cntChan),
    .cntData(cntData), .tcPulse(tcPulse)
  );

  assign xferReq  = strobe.offer;
  assign xferChan = ptr;

endmodule

// File: rtl/dma_svc_checker.sv
module dma_svc_checker #(
  parameter int NCH   = 8,
  parameter int PTR_W = 3,
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NCH-1:0]         chanMask,
  input logic [NCH-1:0]         chanReq,
  input logic [NCH-1:0][7:0]    chanMode,
  input logic                   xferReq,
  input logic [PTR_W-1:0]       xferChan,
  input logic                   xferMemWrite,
  input logic                   xferAck,
  input logic                   cntWe,
  input logic [PTR_W-1:0]       cntChan,
  input logic [NCH-1:0]         tcPulse
);

  a_r11_hold_offer: assert property (@(posedge clk) disable iff (!rstN)
    xferReq && !xferAck |=> xferReq && $stable(xferChan));

  a_r4_offer_eligible: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferReq) |-> !$past(chanMask[xferChan]) && $past(chanReq[xferChan]));

  a_r6_write_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    cntWe |-> $past(xferReq && xferAck));

  a_r7_tc_with_write: assert property (@(posedge clk) disable iff (!rstN)
    (tcPulse != '0) |-> cntWe && $onehot0(tcPulse));

  a_r8_no_cascade_tc: assert property (@(posedge clk) disable iff (!rstN)
    (tcPulse != '0) |-> chanMode[cntChan][7:6] != 2'b11);

  a_r9_write_only_offered: assert property (@(posedge clk) disable iff (!rstN)
    xferMemWrite |-> xferReq);

endmodule

bind dma_svc_engine dma_svc_checker #(
  .NCH(NCH), .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_svc_chk (
  .clk(clk), .rstN(rstN), .chanMask(chanMask), .chanReq(chanReq),
  .chanMode(chanMode), .xferReq(xferReq), .xferChan(xferChan),
  .xferMemWrite(xferMemWrite), .xferAck(xferAck), .cntWe(cntWe),
  .cntChan(cntChan), .tcPulse(tcPulse)
);

// File: tb/test_dma_svc_engine.sv
module test_dma_svc_engine;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 tick = 1'b0;
  logic [1:0][7:0]      ctrlCmd = '0;
  logic [7:0]           chanMask = '0;
  logic [7:0]           chanReq = '0;
  logic [7:0][7:0]      chanMode = '0;
  logic [7:0][15:0]     baseCount = '0;
  logic [7:0][15:0]     curCount = '0;
  logic                 xferReq;
  logic [2:0]           xferChan;
  logic [17:0]          xferStart;
  logic [17:0]          xferSize;
  logic                 xferMemWrite;
  logic                 xferAck = 1'b0;
  logic [17:0]          xferEnd = '0;
  logic                 cntWe;
  logic [2:0]           cntChan;
  logic [15:0]          cntData;
  logic [7:0]           tcPulse;

  logic [17:0] endRet [8];

  typedef struct {
    int          chan;
    logic [17:0] start;
    logic [17:0] size;
    logic        memWr;
    logic [15:0] data;
    logic        tc;
  } item_t;

  item_t reqQ[$];
  item_t wrQ[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dma_svc_engine i_dma_svc_engine (
    .clk(clk), .rstN(rstN), .tick(tick), .ctrlCmd(ctrlCmd),
    .chanMask(chanMask), .chanReq(chanReq), .chanMode(chanMode),
    .baseCount(baseCount), .curCount(curCount),
    .xferReq(xferReq), .xferChan(xferChan), .xferStart(xferStart),
    .xferSize(xferSize), .xferMemWrite(xferMemWrite), .xferAck(xferAck),
    .xferEnd(xferEnd), .cntWe(cntWe), .cntChan(cntChan),
    .cntData(cntData), .tcPulse(tcPulse)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: compute the expected service list of one scan from the requirements
  task automatic planPass(input logic [7:0] m, input logic [7:0] r, input logic [1:0] off);
    for (int c = 0; c < 8; c++) begin
      item_t       it;
      int          w;
      logic [17:0] sc;
      w = (c >= 4) ? 1 : 0;
      if (!off[c / 4] && !m[c] && r[c]) begin
        it.chan  = c;
        it.start = 18'(curCount[c]) << w;
        it.size  = (18'(baseCount[c]) + 18'd1) << w;
        it.memWr = (chanMode[c][3:2] == 2'b01);
        sc       = endRet[c] >> w;
        it.data  = sc[15:0];
        it.tc    = (sc == 18'(baseCount[c]) + 18'd1) && (chanMode[c][7:6] != 2'b11);
        reqQ.push_back(it);
        wrQ.push_back(it);
      end
    end
  endtask

  task automatic pulseTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic drainPass(input string tag);
    while (reqQ.size() != 0 || wrQ.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    check(reqQ.size() == 0 && wrQ.size() == 0 && !xferReq, tag, xferReq, 0);
  endtask

  task automatic runPass(input string tag);
    planPass(chanMask, chanReq, {ctrlCmd[1][2], ctrlCmd[0][2]});
    pulseTick();
    drainPass(tag);
  endtask

  // Responder and request monitor: compares each offer, acknowledges a cycle late
  initial begin
    forever begin
      @(negedge clk);
      if (xferReq && rstN) begin
        if (reqQ.size() == 0) begin
          check(0, "R2 unexpected offer", xferChan, 0);
        end else begin
          item_t it;
          logic [2:0] held;
          it = reqQ.pop_front();
          check(xferChan == 3'(it.chan) && xferStart == it.start && xferSize == it.size,
                "R2/R4/R5 offer chan/start/size",
                {xferChan, xferStart, xferSize}, {3'(it.chan), it.start, it.size});
          check(xferMemWrite == it.memWr, "R9 memory write qualifier", xferMemWrite, it.memWr);
          held = xferChan;
          @(negedge clk);
          check(xferReq && xferChan == held, "R11 offer held until ack", xferChan, held);
          xferEnd = endRet[held];
          xferAck = 1'b1;
          @(negedge clk);
          xferAck = 1'b0;
        end
      end
    end
  end

  // Monitor: count writes and terminal-count pulses
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (tcPulse != 8'h0 && !cntWe)
          check(0, "R7 tc pulse without count write", tcPulse, 0);
        if (cntWe) begin
          if (wrQ.size() == 0) begin
            check(0, "R6 unexpected count write", cntChan, 0);
          end else begin
            item_t it;
            logic [7:0] expTc;
            it = wrQ.pop_front();
            expTc = it.tc ? (8'd1 << it.chan) : 8'd0;
            check(cntChan == 3'(it.chan) && cntData == it.data,
                  "R6/R10 count write", {cntChan, cntData}, {3'(it.chan), it.data});
            check(tcPulse == expTc, "R7/R8 terminal count", tcPulse, expTc);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // Channel setup: modes, counts and device returns
    chanMode[0] = 8'h44; baseCount[0] = 16'h0010; curCount[0] = 16'h0000; endRet[0] = 18'h00011;
    chanMode[1] = 8'h00; baseCount[1] = 16'h0020; curCount[1] = 16'h0005; endRet[1] = 18'h00010;
    chanMode[2] = 8'h88; baseCount[2] = 16'h0007; curCount[2] = 16'h0000; endRet[2] = 18'h00008;
    chanMode[3] = 8'hC4; baseCount[3] = 16'h0003; curCount[3] = 16'h0000; endRet[3] = 18'h00004;
    chanMode[4] = 8'h04; baseCount[4] = 16'h000F; curCount[4] = 16'h0002; endRet[4] = 18'h00020;
    chanMode[5] = 8'h48; baseCount[5] = 16'h0100; curCount[5] = 16'h0080; endRet[5] = 18'h00150;
    chanMode[6] = 8'h54; baseCount[6] = 16'h0040; curCount[6] = 16'h0030; endRet[6] = 18'h00008;
    chanMode[7] = 8'h8C; baseCount[7] = 16'h0000; curCount[7] = 16'h0000; endRet[7] = 18'h00002;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!xferReq && !cntWe && tcPulse == 8'h0, "R1 reset state",
          {xferReq, cntWe, tcPulse}, 0);

    // All channels requesting with mixed modes
    chanReq = 8'hFF;
    runPass("R2/R7/R8/R10 full scan");

    // Byte-wide controller switched off
    ctrlCmd[0] = 8'h04;
    runPass("R3 controller 0 off");
    ctrlCmd[0] = 8'h00;

    // Word-wide controller switched off
    ctrlCmd[1] = 8'h04;
    runPass("R3 controller 1 off");
    ctrlCmd[1] = 8'h00;

    // Sparse mask
    chanMask = 8'h5A;
    runPass("R4 sparse mask");
    chanMask = 8'h00;

    // Mask channel 6 right after the scan starts
    chanReq = 8'h42;
    planPass(8'h40, chanReq, 2'b00);
    pulseTick();
    chanMask = 8'h40;
    drainPass("R4 mask mid-scan");
    runPass("R4 mask holds next pass");
    chanMask = 8'h00;
    runPass("R4 unmask restores service");

    // No requests at all
    chanReq = 8'h00;
    runPass("R1/R2 silent scan");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule